// File: doc/BRIEF.md
# Dryer Cycle Sequencer

This block is the phase controller of a clothes dryer. Once a program is started it walks the machine through four phases. First comes a heated drying phase. Next is a cool-down phase, in which the drum turns but the heater is off. Then comes an anti-crease phase, which alternates short tumbling bursts with longer pauses. Last, the machine rests in a stop phase that flags completion. Three program families are offered: cotton, with six dryness levels; permanent press, with three; and timed drying, with three durations. The program and its level are captured when the cycle starts, so the front panel may change while the cycle runs.

The sensor programs end drying when an external humidity comparator reports that the selected target has been reached. The timed program ignores that comparator and counts seconds instead. Both ways of ending the drying phase lead into the same path. Elapsed time comes from a tick input. A parameter sets how many tick pulses make one second, so a fast tick can stand in for a slow one. The sensors arrive as single-bit flags, and the outputs are plain enables plus a phase code.

Top module: `dryer_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, phase_o is 0 (idle) and heater_o, motor_o and done_o are low.
- R2: A start pulse is accepted only when the phase is idle (0) or stop (4) and the program/level pair is valid. Valid pairs are: program code 0 (cotton) with level 0..5, code 1 (permanent press) with level 0..2, and code 2 (timed) with level 0..2. In the cycle after acceptance, phase_o reads 1 (drying).
- R3: A start pulse with program code 3, or with a level outside the program's range, leaves the phase unchanged.
- R4: heater_o is high only in drying. motor_o is high throughout drying and cool-down, and low in idle and stop.
- R5: In the cotton and permanent-press programs, a high humidity flag during drying moves the phase to 2 (cool-down) on the next cycle, and drying continues while the flag is low.
- R6: In the timed program, drying lasts exactly DRY_T0, DRY_T1 or DRY_T2 seconds (defaults 900, 1200 and 1800) for level 0, 1 or 2. The humidity flag has no effect, and the program and level are the ones captured at start.
- R7: Cool-down keeps heater_o low and motor_o high until the cool flag is seen. The phase then becomes 3 (anti-crease) on the next cycle.
- R8: In anti-crease, motor_o is high for the first AC_ON seconds (default 10) of every AC_ON+AC_OFF second period (default 40), counted from phase entry, and low for the rest of the period.
- R9: Anti-crease lasts exactly AC_TOTAL seconds (default 300), even when that cuts a period short, and then moves to stop (4). In stop, done_o is high and heater_o and motor_o are low.
- R10: A start pulse during drying, cool-down or anti-crease is ignored. It neither restarts the phase nor alters the timing.
- R11: One second equals SEC_DIV pulses of tick_i. A start pulse clears any partial count of tick pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, one cycle |
| prog_i | input | 2 | Program: 0 cotton, 1 permanent press, 2 timed, 3 none |
| set_i | input | 3 | Dryness level or duration index |
| hum_i | input | 1 | Humidity target reached |
| cool_i | input | 1 | Load has reached cool temperature |
| tick_i | input | 1 | Time-base pulse |
| heater_o | output | 1 | Heater enable |
| motor_o | output | 1 | Tumble motor enable |
| phase_o | output | 3 | 0 idle, 1 drying, 2 cool-down, 3 anti-crease, 4 stop |
| done_o | output | 1 | Cycle finished |

## Verification
The bench sweeps every program/level pair. Each invalid pair must leave the phase untouched; a design with a loose range check would start a cycle. Each valid pair is run through a complete cycle. During every cycle the front-panel inputs are changed and stray starts are injected, which shows up a design that fails to latch the selection or restarts its timer. Timed drying is paced by a gapped tick and checked for an exact count, so an off-by-one limit or a tick counted outside drying shows up as a wrong count. Every anti-crease second is compared with the 10-on/30-off pattern, and the phase must end at second 300, partway through a pause. A second instance with a divided time base is used to confirm that seconds are built from whole groups of pulses.

// File: rtl/dryer_pkg.sv
package dryer_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_DRY    = 3'd1,
      PH_COOL   = 3'd2,
      PH_CREASE = 3'd3,
      PH_STOP   = 3'd4
   } phase_e;

   typedef enum logic [1:0] {
      PG_COTTON = 2'd0,
      PG_PERM   = 2'd1,
      PG_TIMED  = 2'd2,
      PG_NONE   = 2'd3
   } prog_e;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dry_sec_prescale.sv
module dry_sec_prescale #(
   parameter int SEC_DIV = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic tick_i,
   output logic sec_o
);

   if (SEC_DIV < 1) begin : g_bad_div
      $error("dry_sec_prescale: SEC_DIV must be at least 1");
   end

   if (SEC_DIV == 1) begin : g_pass
      logic unused_pass;
      assign unused_pass = &{1'b0, clk, rst_n, clr_i};
      assign sec_o = tick_i;
   end else begin : g_div
      localparam int PW = $clog2(SEC_DIV);
      localparam logic [PW-1:0] LAST = PW'(SEC_DIV - 1);
      logic [PW-1:0] pcnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pcnt_q <= '0;
         end else if (clr_i) begin
            pcnt_q <= '0;
         end else if (tick_i) begin
            pcnt_q <= (pcnt_q == LAST) ? '0 : pcnt_q + 1'b1;
         end
      end

      assign sec_o = tick_i && !clr_i && (pcnt_q == LAST);
   end

endmodule

// File: rtl/dry_sec_count.sv
module dry_sec_count #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         en_i,
   input  logic [W-1:0] limit_i,
   output logic         hit_o
);

   if (W < 1) begin : g_bad_w
      $error("dry_sec_count: W must be at least 1");
   end

   logic [W-1:0] cnt_q;
   logic         at_last;

   assign at_last = (cnt_q == (limit_i - W'(1)));
   assign hit_o   = en_i && at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (en_i) begin
         cnt_q <= at_last ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/dry_crease_pattern.sv
module dry_crease_pattern #(
   parameter int AC_ON    = 10,
   parameter int AC_OFF   = 30,
   parameter int AC_TOTAL = 300,
   parameter int W        = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic sec_i,
   output logic tumble_o,
   output logic end_o
);

   localparam int PERIOD = AC_ON + AC_OFF;
   localparam int SW     = $clog2(PERIOD + 1);
   localparam logic [SW-1:0] SLOT_LAST = SW'(PERIOD - 1);
   localparam logic [SW-1:0] SLOT_ON   = SW'(AC_ON);

   if (AC_ON < 1 || AC_OFF < 1) begin : g_bad_duty
      $error("dry_crease_pattern: AC_ON and AC_OFF must be at least 1");
   end
   if (AC_TOTAL < 1 || AC_TOTAL >= (1 << W)) begin : g_bad_total
      $error("dry_crease_pattern: AC_TOTAL must be positive and fit in W bits");
   end

   logic [SW-1:0] slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (clr_i) begin
         slot_q <= '0;
      end else if (sec_i) begin
         slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
      end
   end

   assign tumble_o = (slot_q < SLOT_ON);

   dry_sec_count #(
      .W (W)
   ) u_total (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr_i),
      .en_i    (sec_i),
      .limit_i (W'(AC_TOTAL)),
      .hit_o   (end_o)
   );

endmodule

// File: rtl/dryer_seq.sv
module dryer_seq
   import dryer_pkg::*;
#(
   parameter int SEC_DIV  = 1,
   parameter int COTTON_N = 6,
   parameter int PERM_N   = 3,
   parameter int DRY_T0   = 900,
   parameter int DRY_T1   = 1200,
   parameter int DRY_T2   = 1800,
   parameter int AC_ON    = 10,
   parameter int AC_OFF   = 30,
   parameter int AC_TOTAL = 300
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic [1:0] prog_i,
   input  logic [2:0] set_i,
   input  logic       hum_i,
   input  logic       cool_i,
   input  logic       tick_i,
   output logic       heater_o,
   output logic       motor_o,
   output logic [2:0] phase_o,
   output logic       done_o
);

   localparam int TIMED_N = 3;
   localparam int T_MAX   = max_of(max_of(DRY_T0, DRY_T1), max_of(DRY_T2, AC_TOTAL));
   localparam int CW      = $clog2(T_MAX + 1);

   if (COTTON_N < 1 || COTTON_N > 8 || PERM_N < 1 || PERM_N > 8) begin : g_bad_levels
      $error("dryer_seq: level counts must lie in 1..8");
   end
   if (DRY_T0 < 1 || DRY_T1 < 1 || DRY_T2 < 1) begin : g_bad_times
      $error("dryer_seq: timed durations must be positive");
   end

   phase_e      phase_q, phase_d;
   prog_e       prog_q;
   logic [2:0]  set_q;
   logic        sel_ok, accept;
   logic        sec_tick, pre_clr;
   logic [CW-1:0] dry_limit;
   logic        dry_en, dry_hit, dry_end;
   logic        crease_tumble, crease_end;

   // selection check against the per-program level count
   always_comb begin
      unique case (prog_i)
         2'd0:    sel_ok = (int'(set_i) < COTTON_N);
         2'd1:    sel_ok = (int'(set_i) < PERM_N);
         2'd2:    sel_ok = (int'(set_i) < TIMED_N);
         default: sel_ok = 1'b0;
      endcase
   end

   assign accept  = start_i && sel_ok && (phase_q == PH_IDLE || phase_q == PH_STOP);
   assign pre_clr = accept || (phase_q == PH_COOL && cool_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_q <= PG_NONE;
         set_q  <= '0;
      end else if (accept) begin
         prog_q <= prog_e'(prog_i);
         set_q  <= set_i;
      end
   end

   dry_sec_prescale #(
      .SEC_DIV (SEC_DIV)
   ) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (pre_clr),
      .tick_i (tick_i),
      .sec_o  (sec_tick)
   );

   always_comb begin
      unique case (set_q)
         3'd0:    dry_limit = CW'(DRY_T0);
         3'd1:    dry_limit = CW'(DRY_T1);
         default: dry_limit = CW'(DRY_T2);
      endcase
   end

   assign dry_en = sec_tick && (phase_q == PH_DRY) && (prog_q == PG_TIMED);

   dry_sec_count #(
      .W (CW)
   ) u_dry_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (phase_q != PH_DRY),
      .en_i    (dry_en),
      .limit_i (dry_limit),
      .hit_o   (dry_hit)
   );

   // humidity-ended and time-ended drying merge into one exit condition
   assign dry_end = (prog_q == PG_TIMED) ? dry_hit : hum_i;

   dry_crease_pattern #(
      .AC_ON    (AC_ON),
      .AC_OFF   (AC_OFF),
      .AC_TOTAL (AC_TOTAL),
      .W        (CW)
   ) u_crease (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (phase_q != PH_CREASE),
      .sec_i    (sec_tick && phase_q == PH_CREASE),
      .tumble_o (crease_tumble),
      .end_o    (crease_end)
   );

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE, PH_STOP: if (accept)     phase_d = PH_DRY;
         PH_DRY:           if (dry_end)    phase_d = PH_COOL;
         PH_COOL:          if (cool_i)     phase_d = PH_CREASE;
         PH_CREASE:        if (crease_end) phase_d = PH_STOP;
         default:                          phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_d;
   end

   assign phase_o  = phase_q;
   assign heater_o = (phase_q == PH_DRY);
   assign motor_o  = (phase_q == PH_DRY) || (phase_q == PH_COOL) ||
                     ((phase_q == PH_CREASE) && crease_tumble);
   assign done_o   = (phase_q == PH_STOP);

endmodule

// File: rtl/dryer_seq_chk.sv
module dryer_seq_chk
   import dryer_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       hum_i,
   input logic       cool_i,
   input logic       heater_o,
   input logic       motor_o,
   input logic [2:0] phase_o,
   input logic       done_o,
   input logic [1:0] prog_q,
   input logic       sec_tick
);

   AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o <= 3'd4); // R1

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == PH_IDLE && !start_i) |=> phase_o == PH_IDLE); // R3

   AST_HEAT_IN_DRY: assert property (@(posedge clk) disable iff (!rst_n)
      heater_o |-> phase_o == PH_DRY); // R4

   AST_MOTOR_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == PH_DRY || phase_o == PH_COOL) |-> motor_o); // R4

   AST_HUM_ENDS_DRY: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == PH_DRY && prog_q != PG_TIMED && hum_i) |=> phase_o == PH_COOL); // R5

   AST_TIMED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == PH_DRY && prog_q == PG_TIMED && !sec_tick) |=> phase_o == PH_DRY); // R6

   AST_COOL_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == PH_COOL && !cool_i) |=> phase_o == PH_COOL); // R7

   AST_CREASE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o == PH_CREASE |=> (phase_o == PH_CREASE || phase_o == PH_STOP)); // R9

   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!heater_o && !motor_o)); // R9

   AST_DRY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o == PH_DRY |=> (phase_o == PH_DRY || phase_o == PH_COOL)); // R10

endmodule

bind dryer_seq dryer_seq_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .hum_i    (hum_i),
   .cool_i   (cool_i),
   .heater_o (heater_o),
   .motor_o  (motor_o),
   .phase_o  (phase_o),
   .done_o   (done_o),
   .prog_q   (prog_q),
   .sec_tick (sec_tick)
);

// File: tb/dryer_seq_bench.sv
`timescale 1ns/1ps
module dryer_seq_bench;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       start_i, start2_i;
   logic [1:0] prog_i;
   logic [2:0] set_i;
   logic       hum_i, cool_i, tick_i;
   logic       heater_o, motor_o, done_o;
   logic [2:0] phase_o;
   logic       heater2, motor2, done2;
   logic [2:0] phase2;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #2.5 clk = ~clk;

   dryer_seq u_dryer_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .prog_i(prog_i), .set_i(set_i),
      .hum_i(hum_i), .cool_i(cool_i), .tick_i(tick_i),
      .heater_o(heater_o), .motor_o(motor_o), .phase_o(phase_o), .done_o(done_o)
   );

   dryer_seq #(
      .SEC_DIV(3), .DRY_T0(4), .DRY_T1(5), .DRY_T2(6)
   ) u_div (
      .clk(clk), .rst_n(rst_n), .start_i(start2_i), .prog_i(prog_i), .set_i(set_i),
      .hum_i(hum_i), .cool_i(cool_i), .tick_i(tick_i),
      .heater_o(heater2), .motor_o(motor2), .phase_o(phase2), .done_o(done2)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   function automatic bit sel_valid(input int p, input int s);
      return (p == 0 && s < 6) || (p == 1 && s < 3) || (p == 2 && s < 3);
   endfunction

   function automatic int dry_secs(input int s);
      return (s == 0) ? 900 : (s == 1) ? 1200 : 1800;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic run_cycle(input int p, input int s);
      int cnt;
      prog_i = p[1:0]; set_i = s[2:0];
      start_i = 1'b1; tick_i = 1'b0; hum_i = 1'b0; cool_i = 1'b0;
      step();
      start_i = 1'b0;
      check(phase_o == 3'd1, "R2 start accepted", phase_o, 1);
      check(heater_o && motor_o, "R4 drying outputs", {heater_o, motor_o}, 3);
      // change the panel: cotton level 0 would end on humidity if not latched
      prog_i = 2'd0; set_i = 3'd0;
      if (p != 2) begin
         for (int i = 0; i < 6; i++) begin
            tick_i  = ~tick_i;
            start_i = (i == 2);
            step();
            check(phase_o == 3'd1, "R5 R10 drying holds without humidity", phase_o, 1);
         end
         start_i = 1'b0;
         hum_i = 1'b1;
         step();
         check(phase_o == 3'd2, "R5 humidity ends drying", phase_o, 2);
      end else begin
         hum_i = 1'b1;
         cnt = 0;
         for (int i = 0; i < 5000 && phase_o == 3'd1; i++) begin
            tick_i  = (i % 2 == 0);
            start_i = (i == 7);
            if (tick_i) cnt++;
            step();
         end
         start_i = 1'b0;
         check(cnt == dry_secs(s), "R6 R10 timed drying length", cnt, dry_secs(s));
         check(phase_o == 3'd2, "R6 timed drying exits to cool-down", phase_o, 2);
      end
      hum_i = 1'b0; tick_i = 1'b1;
      for (int i = 0; i < 4; i++) begin
         start_i = (i == 1);
         step();
         check(phase_o == 3'd2 && !heater_o && motor_o, "R7 R10 cool-down holds",
               {phase_o, heater_o, motor_o}, 9);
      end
      start_i = 1'b0;
      cool_i = 1'b1;
      step();
      cool_i = 1'b0;
      check(phase_o == 3'd3, "R7 cool flag enters anti-crease", phase_o, 3);
      for (int k = 0; k < 300; k++) begin
         check(motor_o == ((k % 40) < 10), "R8 tumble pattern", motor_o, int'((k % 40) < 10));
         check(phase_o == 3'd3 && !heater_o, "R9 anti-crease duration", phase_o, 3);
         start_i = (k == 55);
         step();
      end
      start_i = 1'b0;
      tick_i = 1'b0;
      check(phase_o == 3'd4, "R9 stop after anti-crease", phase_o, 4);
      check(done_o && !motor_o && !heater_o, "R9 stop outputs",
            {done_o, motor_o, heater_o}, 4);
   endtask

   initial begin
      int cnt;
      logic [2:0] prev;
      rst_n = 1'b0; start_i = 1'b0; start2_i = 1'b0; prog_i = 2'd0; set_i = 3'd0;
      hum_i = 1'b0; cool_i = 1'b0; tick_i = 1'b0;
      step(); step();
      check(phase_o == 3'd0 && !heater_o && !motor_o && !done_o, "R1 reset state",
            {phase_o, heater_o, motor_o, done_o}, 0);
      rst_n = 1'b1;
      step();
      check(phase_o == 3'd0 && !heater_o && !motor_o && !done_o, "R1 after reset",
            {phase_o, heater_o, motor_o, done_o}, 0);

      for (int p = 0; p < 4; p++) begin
         for (int s = 0; s < 8; s++) begin
            if (sel_valid(p, s)) begin
               run_cycle(p, s);
            end else begin
               prev = phase_o;
               prog_i = p[1:0]; set_i = s[2:0]; start_i = 1'b1; hum_i = 1'b1;
               step();
               start_i = 1'b0; hum_i = 1'b0;
               check(phase_o == prev, "R3 invalid start ignored", phase_o, prev);
               step();
               check(phase_o == prev && !heater_o && !motor_o, "R3 R4 still quiet",
                     phase_o, prev);
            end
         end
      end

      // divided time base: 6 seconds at 3 pulses each
      prog_i = 2'd2; set_i = 3'd2; start2_i = 1'b1; tick_i = 1'b0;
      step();
      start2_i = 1'b0;
      check(phase2 == 3'd1, "R11 divided instance starts", phase2, 1);
      cnt = 0;
      for (int i = 0; i < 500 && phase2 == 3'd1; i++) begin
         tick_i = (i % 3 != 2);
         if (tick_i) cnt++;
         step();
      end
      tick_i = 1'b0;
      check(cnt == 18, "R11 pulses per second", cnt, 18);
      check(phase2 == 3'd2, "R11 divided instance reaches cool-down", phase2, 2);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule